// File: doc/BRIEF.md
# Timer/Counter with Shared Prescaler

This block is an 8-bit timer/counter for a small controller. It counts either the instruction-cycle tick or edges on an external count pin. A programmable power-of-two prescaler sits in front of it. The prescaler is shared with a watchdog tick path, and one option bit hands it to one destination or the other. Whichever path does not own the prescaler runs undivided.

The oscillator clock is split into a four-phase instruction cycle. The instruction tick fires once per four oscillator periods. The prescaler output is taken into the timer only on the second and fourth phase. The external count pin and the external interrupt pin are each passed through a two-stage synchroniser and an edge detector whose polarity is programmable. The timer sets a sticky flag when it wraps. The interrupt pin sets its own sticky flag. The watchdog path emits a one-cycle timeout pulse.

Top module: `tmr_presc_top`

## Requirements
- R1: After reset the option register reads 0xFF, the timer reads 0x00, and both flags and the timeout output are 0.
- R2: The option register holds the value written to it. Its fields are: bits [2:0] rate code; bit 3 prescaler owner (1 = watchdog, 0 = timer); bit 4 count edge (1 = falling, 0 = rising); bit 5 count source (1 = external pin, 0 = instruction tick); bit 6 interrupt edge (1 = rising, 0 = falling); bit 7 a spare storage bit. The option register changes only on a write.
- R3: With the instruction tick as source and no prescaling on the timer, the timer advances once every four clock cycles. Without a write it changes by at most +1 per cycle.
- R4: With the external pin as source, the timer counts the selected edge. Every pulse that stays high for at least 2 cycles and low for at least 2 cycles is counted.
- R5: When the prescaler belongs to the timer, the timer advances once per 2^(code+1) source events, from 1:2 up to 1:256.
- R6: When the prescaler belongs to the watchdog, the timer counts every source event and a timeout pulse follows every 2^code watchdog ticks. When the prescaler belongs to the timer, every watchdog tick gives a timeout pulse. Each pulse appears one cycle after its tick.
- R7: A wrap from 0xFF to 0x00 sets a sticky overflow flag. Only the overflow clear input clears it, and a wrap in the same cycle as a clear leaves the flag set.
- R8: A timer write loads the value and clears the prescaler count. The option register is left unchanged.
- R9: A change of prescaler owner clears the prescaler count.
- R10: The watchdog clear input resets the watchdog prescaler count. A tick in the same cycle as a clear gives no timeout pulse.
- R11: The selected edge on the interrupt pin sets a sticky interrupt flag, and the opposite edge has no effect. Only the interrupt clear input clears the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| opt_we_i | input | 1 | Option register write strobe |
| opt_wdata_i | input | 8 | Option register write data |
| opt_o | output | 8 | Option register contents |
| tmr_we_i | input | 1 | Timer write strobe |
| tmr_wdata_i | input | TMR_W | Timer write data |
| tmr_o | output | TMR_W | Current timer value |
| cnt_pin_i | input | 1 | External count pin, asynchronous |
| irq_pin_i | input | 1 | External interrupt pin, asynchronous |
| wdt_tick_i | input | 1 | Watchdog base tick, one cycle wide |
| wdt_clr_i | input | 1 | Watchdog clear |
| ovf_clr_i | input | 1 | Overflow flag clear |
| irq_clr_i | input | 1 | Interrupt flag clear |
| ovf_flag_o | output | 1 | Sticky timer overflow flag |
| irq_flag_o | output | 1 | Sticky external interrupt flag |
| wdt_to_o | output | 1 | Watchdog timeout pulse |

## Verification
Two pairs of events can land in the same cycle, and each pair has a fixed winner. A watchdog tick can coincide with a watchdog clear. The bench raises both inputs on the same cycle with a 1:1 watchdog ratio, checks that no timeout pulse appears, and then checks that a lone tick does give one. A timer wrap can coincide with an overflow clear. The bench holds the clear high while it drives the timer from 0xFE across the wrap, and counts the cycles in which the flag is seen high. Exactly one such cycle is expected, because the set wins in the wrap cycle and the clear takes effect on the next one.

// File: rtl/tp_pkg.sv
package tp_pkg;
  localparam int RATE_W = 3;
  localparam int PRE_W  = 1 << RATE_W;

  typedef struct packed {
    logic              spare;
    logic              irq_rise;
    logic              src_ext;
    logic              cnt_fall;
    logic              to_wdt;
    logic [RATE_W-1:0] rate;
  } opt_t;

  localparam int   OPT_W   = $bits(opt_t);
  localparam opt_t OPT_RST = '1;
endpackage

// File: rtl/tp_phase.sv
module tp_phase #(
  parameter int PHASES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o,
  output logic samp_o
);
  localparam int PH_W = $clog2(PHASES);
  localparam int HALF = PHASES / 2;

  logic [PH_W-1:0] ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          ph_q <= '0;
    else if (ph_q == PH_W'(PHASES - 1))   ph_q <= '0;
    else                                  ph_q <= ph_q + 1'b1;
  end

  assign tick_o = (ph_q == PH_W'(PHASES - 1));
  // sample on mid-cycle phase and last phase
  assign samp_o = (ph_q == PH_W'(HALF - 1)) || tick_o;
endmodule

// File: rtl/tp_edge.sv
module tp_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic fall_sel_i,
  output logic edge_o
);
  logic [STAGES:0] sh_q;
  logic            cur, prev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], pin_i};
  end

  assign cur    = sh_q[STAGES-1];
  assign prev   = sh_q[STAGES];
  assign edge_o = fall_sel_i ? (!cur && prev) : (cur && !prev);
endmodule

// File: rtl/tp_presc.sv
module tp_presc #(
  parameter int RATE_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              to_wdt_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              src_evt_i,
  input  logic              wdt_tick_i,
  input  logic              wdt_clr_i,
  output logic              tmr_evt_o,
  output logic              wdt_evt_o
);
  localparam int PRE_W = 1 << RATE_W;

  logic [PRE_W-1:0] cnt_q, mask_w, mask_t;
  logic             tap_w, tap_t, inc, clr;

  always_comb begin
    mask_w = '0;
    for (int i = 0; i < PRE_W; i++)
      if (i < int'(rate_i)) mask_w[i] = 1'b1;
    mask_t = {mask_w[PRE_W-2:0], 1'b1};
  end

  assign tap_w = &(cnt_q | ~mask_w);
  assign tap_t = &(cnt_q | ~mask_t);
  assign inc   = to_wdt_i ? (wdt_tick_i && !wdt_clr_i) : src_evt_i;
  assign clr   = clr_i || (to_wdt_i && wdt_clr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else if (inc) cnt_q <= cnt_q + 1'b1;
  end

  assign tmr_evt_o = to_wdt_i ? src_evt_i : (src_evt_i && tap_t);
  assign wdt_evt_o = wdt_tick_i && !wdt_clr_i && (!to_wdt_i || tap_w);
endmodule

// File: rtl/tp_timer.sv
module tp_timer #(
  parameter int TMR_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             samp_i,
  input  logic             evt_i,
  input  logic             we_i,
  input  logic [TMR_W-1:0] wdata_i,
  input  logic             ovf_clr_i,
  output logic [TMR_W-1:0] tmr_o,
  output logic             ovf_o
);
  logic [TMR_W-1:0] tmr_q;
  logic             pend_q, ovf_q, wrap;

  // event held until the next sampling phase
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_q  <= '0;
      pend_q <= 1'b0;
    end else if (we_i) begin
      tmr_q  <= wdata_i;
      pend_q <= 1'b0;
    end else if (samp_i) begin
      pend_q <= evt_i;
      if (pend_q) tmr_q <= tmr_q + 1'b1;
    end else begin
      pend_q <= pend_q || evt_i;
    end
  end

  assign wrap = !we_i && samp_i && pend_q && (&tmr_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ovf_q <= 1'b0;
    else if (wrap)      ovf_q <= 1'b1;
    else if (ovf_clr_i) ovf_q <= 1'b0;
  end

  assign tmr_o = tmr_q;
  assign ovf_o = ovf_q;
endmodule

// File: rtl/tmr_presc_top.sv
module tmr_presc_top
  import tp_pkg::*;
#(
  parameter int TMR_W       = 8,
  parameter int PHASES      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             opt_we_i,
  input  logic [7:0]       opt_wdata_i,
  output logic [7:0]       opt_o,
  input  logic             tmr_we_i,
  input  logic [TMR_W-1:0] tmr_wdata_i,
  output logic [TMR_W-1:0] tmr_o,
  input  logic             cnt_pin_i,
  input  logic             irq_pin_i,
  input  logic             wdt_tick_i,
  input  logic             wdt_clr_i,
  input  logic             ovf_clr_i,
  input  logic             irq_clr_i,
  output logic             ovf_flag_o,
  output logic             irq_flag_o,
  output logic             wdt_to_o
);
  opt_t opt_q, opt_d;
  logic inst_tick, samp, cnt_edge, irq_edge;
  logic src_evt, tmr_evt, wdt_evt, owner_chg, pre_clr;
  logic irq_q, wdt_to_q;

  assign opt_d = opt_t'(opt_wdata_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       opt_q <= OPT_RST;
    else if (opt_we_i) opt_q <= opt_d;
  end

  assign owner_chg = opt_we_i && (opt_d.to_wdt != opt_q.to_wdt);
  assign pre_clr   = tmr_we_i || owner_chg;

  tp_phase #(.PHASES(PHASES)) phase_i (
    .clk_i (clk_i), .rst_ni(rst_ni), .tick_o(inst_tick), .samp_o(samp)
  );

  tp_edge #(.STAGES(SYNC_STAGES)) cnt_sync_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(cnt_pin_i),
    .fall_sel_i(opt_q.cnt_fall), .edge_o(cnt_edge)
  );

  tp_edge #(.STAGES(SYNC_STAGES)) irq_sync_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(irq_pin_i),
    .fall_sel_i(!opt_q.irq_rise), .edge_o(irq_edge)
  );

  assign src_evt = opt_q.src_ext ? cnt_edge : inst_tick;

  tp_presc #(.RATE_W(RATE_W)) presc_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(pre_clr),
    .to_wdt_i(opt_q.to_wdt), .rate_i(opt_q.rate),
    .src_evt_i(src_evt), .wdt_tick_i(wdt_tick_i), .wdt_clr_i(wdt_clr_i),
    .tmr_evt_o(tmr_evt), .wdt_evt_o(wdt_evt)
  );

  tp_timer #(.TMR_W(TMR_W)) timer_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .samp_i(samp), .evt_i(tmr_evt),
    .we_i(tmr_we_i), .wdata_i(tmr_wdata_i), .ovf_clr_i(ovf_clr_i),
    .tmr_o(tmr_o), .ovf_o(ovf_flag_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q    <= 1'b0;
      wdt_to_q <= 1'b0;
    end else begin
      wdt_to_q <= wdt_evt;
      if (irq_edge)       irq_q <= 1'b1;
      else if (irq_clr_i) irq_q <= 1'b0;
    end
  end

  assign opt_o      = opt_q;
  assign irq_flag_o = irq_q;
  assign wdt_to_o   = wdt_to_q;
endmodule

// File: rtl/tp_chk.sv
module tp_chk #(
  parameter int TMR_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             opt_we_i,
  input logic [7:0]       opt_o,
  input logic             tmr_we_i,
  input logic [TMR_W-1:0] tmr_wdata_i,
  input logic [TMR_W-1:0] tmr_o,
  input logic             wdt_tick_i,
  input logic             wdt_clr_i,
  input logic             ovf_clr_i,
  input logic             irq_clr_i,
  input logic             ovf_flag_o,
  input logic             irq_flag_o,
  input logic             wdt_to_o
);
  AST_OPT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !opt_we_i |=> $stable(opt_o)); // R2

  AST_TMR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tmr_we_i |=> (tmr_o == $past(tmr_o)) || (tmr_o == $past(tmr_o) + TMR_W'(1))); // R3

  AST_TMR_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_we_i |=> tmr_o == $past(tmr_wdata_i)); // R8

  AST_OVF_ON_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tmr_we_i && tmr_o == '1) ##1 (tmr_o == '0) |-> ovf_flag_o); // R7

  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_flag_o && !ovf_clr_i |=> ovf_flag_o); // R7

  AST_WDT_FROM_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_to_o |-> $past(wdt_tick_i)); // R6

  AST_WDT_CLR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_clr_i |=> !wdt_to_o); // R10

  AST_IRQ_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_flag_o && !irq_clr_i |=> irq_flag_o); // R11
endmodule

bind tmr_presc_top tp_chk #(.TMR_W(TMR_W)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .opt_we_i(opt_we_i), .opt_o(opt_o),
  .tmr_we_i(tmr_we_i), .tmr_wdata_i(tmr_wdata_i), .tmr_o(tmr_o),
  .wdt_tick_i(wdt_tick_i), .wdt_clr_i(wdt_clr_i), .ovf_clr_i(ovf_clr_i),
  .irq_clr_i(irq_clr_i), .ovf_flag_o(ovf_flag_o), .irq_flag_o(irq_flag_o),
  .wdt_to_o(wdt_to_o)
);

// File: tb/tmr_presc_top_tb_top.sv
module tmr_presc_top_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       opt_we_i = 1'b0, tmr_we_i = 1'b0;
  logic [7:0] opt_wdata_i = '0, tmr_wdata_i = '0;
  logic [7:0] opt_o, tmr_o;
  logic       cnt_pin_i = 1'b0, irq_pin_i = 1'b0;
  logic       wdt_tick_i = 1'b0, wdt_clr_i = 1'b0;
  logic       ovf_clr_i = 1'b0, irq_clr_i = 1'b0;
  logic       ovf_flag_o, irq_flag_o, wdt_to_o;

  int n_chk = 0, n_err = 0;
  int to_seen = 0, ovf_seen = 0, snap = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  tmr_presc_top dut_i (.*);

  always @(negedge clk_i) begin
    if (wdt_to_o)   to_seen++;
    if (ovf_flag_o) ovf_seen++;
  end

  // {code[3:0], to_wdt, fall, pulses[9:0], expected[15:0]}
  localparam int NV = 8;
  localparam logic [31:0] VEC [NV] = '{
    {4'd0, 1'b0, 1'b0, 10'd8,   16'd4},
    {4'd1, 1'b0, 1'b0, 10'd16,  16'd4},
    {4'd2, 1'b0, 1'b1, 10'd24,  16'd3},
    {4'd7, 1'b0, 1'b0, 10'd255, 16'd0},
    {4'd7, 1'b0, 1'b0, 10'd256, 16'd1},
    {4'd5, 1'b1, 1'b0, 10'd7,   16'd7},
    {4'd0, 1'b1, 1'b1, 10'd5,   16'd5},
    {4'd0, 1'b0, 1'b1, 10'd3,   16'd1}
  };

  function automatic logic [7:0] ob(int code, bit to_wdt, bit fall, bit ext, bit rise);
    return {1'b1, rise, ext, fall, to_wdt, 3'(code)};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input int act, input int lo, input int hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wr_opt(input logic [7:0] v);
    opt_wdata_i = v; opt_we_i = 1'b1; wait_n(1); opt_we_i = 1'b0;
  endtask

  task automatic wr_tmr(input logic [7:0] v);
    tmr_wdata_i = v; tmr_we_i = 1'b1; wait_n(1); tmr_we_i = 1'b0;
  endtask

  task automatic pulses(input int n, input int hi, input int lo);
    for (int i = 0; i < n; i++) begin
      cnt_pin_i = 1'b1; wait_n(hi);
      cnt_pin_i = 1'b0; wait_n(lo);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      wdt_tick_i = 1'b1; wait_n(1);
      wdt_tick_i = 1'b0; wait_n(2);
    end
  endtask

  task automatic wclr();
    wdt_clr_i = 1'b1; wait_n(1); wdt_clr_i = 1'b0; wait_n(1);
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    #1200000;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual hung expected done");
      finish_sim();
    end
  end

  initial begin
    wait_n(5);
    rst_ni = 1'b1;
    wait_n(1);
    // R1 reset state
    chk("R1 opt", opt_o, 8'hFF);
    chk("R1 tmr", tmr_o, 0);
    chk("R1 ovf", ovf_flag_o, 0);
    chk("R1 irq", irq_flag_o, 0);
    chk("R1 to", wdt_to_o, 0);

    wr_opt(8'h5A);
    chk("R2 readback", opt_o, 8'h5A);

    // R4 R5 R6 vector walk, external source
    for (int v = 0; v < NV; v++) begin
      wr_opt(ob(int'(VEC[v][31:28]), VEC[v][27], VEC[v][26], 1'b1, 1'b1));
      wr_tmr(8'h00);
      pulses(int'(VEC[v][25:16]), 3, 3);
      wait_n(10);
      chk($sformatf("R4 R5 R6 vec%0d", v), tmr_o, int'(VEC[v][15:0]));
    end

    // R3 instruction tick source
    wr_opt(ob(0, 1'b1, 1'b0, 1'b0, 1'b1));
    wr_tmr(8'h00);
    wait_n(40);
    chk_rng("R3 undivided", tmr_o, 9, 11);
    wr_opt(ob(1, 1'b0, 1'b0, 1'b0, 1'b1));
    wr_tmr(8'h00);
    wait_n(160);
    chk_rng("R3 R5 div4", tmr_o, 9, 11);

    // R4 minimum pulse width
    wr_opt(ob(0, 1'b1, 1'b0, 1'b1, 1'b1));
    wr_tmr(8'h00);
    pulses(20, 2, 2);
    wait_n(10);
    chk("R4 min width", tmr_o, 20);

    // R7 wrap and sticky flag
    wr_tmr(8'hFF);
    chk("R7 no flag yet", ovf_flag_o, 0);
    pulses(1, 3, 3);
    wait_n(10);
    chk("R7 wrap value", tmr_o, 0);
    chk("R7 flag set", ovf_flag_o, 1);
    wait_n(20);
    chk("R7 sticky", ovf_flag_o, 1);
    ovf_clr_i = 1'b1; wait_n(1); ovf_clr_i = 1'b0;
    chk("R7 cleared", ovf_flag_o, 0);
    // R7 wrap while clear held: set wins for one cycle
    wr_tmr(8'hFE);
    ovf_clr_i = 1'b1;
    snap = ovf_seen;
    pulses(2, 3, 3);
    wait_n(10);
    chk("R7 set beats clear", ovf_seen - snap, 1);
    chk("R7 cleared after", ovf_flag_o, 0);
    ovf_clr_i = 1'b0;

    // R8 timer write clears prescaler
    wr_opt(ob(2, 1'b0, 1'b0, 1'b1, 1'b1));
    wr_tmr(8'h00);
    pulses(5, 3, 3);
    wr_tmr(8'h10);
    pulses(7, 3, 3);
    wait_n(10);
    chk("R8 presc cleared", tmr_o, 8'h10);
    chk("R8 opt kept", opt_o, ob(2, 1'b0, 1'b0, 1'b1, 1'b1));

    // R9 owner change clears prescaler
    wr_opt(ob(1, 1'b0, 1'b0, 1'b1, 1'b1));
    wr_tmr(8'h00);
    pulses(3, 3, 3);
    wr_opt(ob(1, 1'b1, 1'b0, 1'b1, 1'b1));
    wr_opt(ob(1, 1'b0, 1'b0, 1'b1, 1'b1));
    pulses(3, 3, 3);
    wait_n(10);
    chk("R9 presc cleared", tmr_o, 0);
    pulses(1, 3, 3);
    wait_n(10);
    chk("R9 then counts", tmr_o, 1);

    // R6 watchdog ratios
    wr_opt(ob(3, 1'b1, 1'b0, 1'b1, 1'b1));
    wclr();
    snap = to_seen;
    ticks(16);
    wait_n(3);
    chk("R6 ratio 8", to_seen - snap, 2);
    snap = to_seen;
    ticks(7);
    wait_n(3);
    chk("R6 partial", to_seen - snap, 0);
    ticks(1);
    wait_n(3);
    chk("R6 eighth", to_seen - snap, 1);
    wr_opt(ob(3, 1'b0, 1'b0, 1'b1, 1'b1));
    snap = to_seen;
    ticks(5);
    wait_n(3);
    chk("R6 undivided", to_seen - snap, 5);

    // R10 watchdog clear
    wr_opt(ob(2, 1'b1, 1'b0, 1'b1, 1'b1));
    wclr();
    snap = to_seen;
    ticks(3);
    wclr();
    ticks(3);
    wait_n(3);
    chk("R10 count reset", to_seen - snap, 0);
    ticks(1);
    wait_n(3);
    chk("R10 after reset", to_seen - snap, 1);
    wr_opt(ob(0, 1'b1, 1'b0, 1'b1, 1'b1));
    snap = to_seen;
    wdt_tick_i = 1'b1; wdt_clr_i = 1'b1; wait_n(1);
    wdt_tick_i = 1'b0; wdt_clr_i = 1'b0; wait_n(3);
    chk("R10 clear beats tick", to_seen - snap, 0);
    ticks(1);
    wait_n(3);
    chk("R10 lone tick", to_seen - snap, 1);

    // R11 interrupt pin
    irq_pin_i = 1'b1; wait_n(5);
    chk("R11 rising set", irq_flag_o, 1);
    irq_clr_i = 1'b1; wait_n(1); irq_clr_i = 1'b0;
    chk("R11 cleared", irq_flag_o, 0);
    irq_pin_i = 1'b0; wait_n(5);
    chk("R11 falling ignored", irq_flag_o, 0);
    wr_opt(ob(0, 1'b1, 1'b0, 1'b1, 1'b0));
    irq_pin_i = 1'b1; wait_n(5);
    chk("R11 rising ignored", irq_flag_o, 0);
    irq_pin_i = 1'b0; wait_n(5);
    chk("R11 falling set", irq_flag_o, 1);
    wait_n(10);
    chk("R11 sticky", irq_flag_o, 1);

    done = 1'b1;
    finish_sim();
  end
endmodule